// File: doc/BRIEF.md
# Dispatch Serialization Barrier

This unit sits at the dispatch point of an out-of-order core. It enforces instruction serialization there. One instruction arrives per cycle with a set of flags:

- a serialize-before mark
- a serialize-after mark
- a control-register-access mark
- a store-conditional mark
- a handled mark
- a temporary mark

Most instructions are forwarded one cycle later with their flags preserved. An unhandled serialize-before instruction or an unhandled control-register access becomes the barrier. The unit holds it and stops accepting input until two things are true in the same cycle: the back end reports empty, and the fetch-queue occupancy input reads zero. The barrier is then released with its serialize-before mark cleared.

An unhandled store-conditional or serialize-after instruction is treated differently. It is forwarded at once, marked handled. A pending flag then forces the next accepted instruction to be treated as serialize-before.

The unit has three named states:

- **RUN** accepts input.
- **BLOCKED** holds the barrier and waits for the drain.
- **COMPLETE** emits the held barrier on its next edge.

The named transitions are:

- *capture*: RUN to BLOCKED
- *drain*: BLOCKED to COMPLETE
- *release*: COMPLETE to RUN
- *discard*: BLOCKED or COMPLETE to RUN, on a squash older than the held barrier

Three free-running counters report:

- serializing barriers plus serialize-after instructions
- temporary barriers
- cycles spent in BLOCKED

Top module: `ser_barrier_unit`

## Requirements
- R1: After reset the unit is in RUN. `in_ready` is 1 while `squash_valid` is 0. `out_valid`, `blocked` and `complete` are 0. All three counters read 0.
- R2: An accepted instruction that is neither a barrier nor an unhandled serialize-after appears on the outputs on the next cycle. It keeps the same sequence number, its serialize-before mark and its handled mark.
- R3: An accepted instruction is a barrier when its serialize-before mark or its control-register-access mark is 1 and its handled mark is 0. On capture it is not forwarded, and from the next cycle `blocked` is 1 and `in_ready` is 0.
- R4: A barrier with temporary mark 0 adds 1 to `cnt_serializing` and is released with handled 1. A barrier with temporary mark 1 adds 1 to `cnt_temporary` and is released with handled 0.
- R5: An unhandled store-conditional or serialize-after instruction is forwarded with handled 1 and adds 1 to `cnt_serializing`. The next accepted instruction is then treated as serialize-before (a barrier if unhandled; otherwise forwarded with serialize-before 1). After that the flag is clear. A serialize-after instruction that is already handled sets no flag.
- R6: BLOCKED moves to COMPLETE only on an edge where `be_empty` is 1 and `queue_count` is 0 together; either alone keeps the unit blocked.
- R7: One cycle after COMPLETE is entered, the held barrier is on the outputs with serialize-before 0 and the unit is back in RUN. No input is accepted while in COMPLETE.
- R8: `cnt_stall` increases by 1 for every clock edge at which the unit is in BLOCKED.
- R9: While a barrier is held, a squash whose sequence number is strictly lower than the barrier's discards the barrier: the unit returns to RUN and the barrier is never emitted. A squash with an equal or higher number has no effect. No input is accepted in a cycle with `squash_valid` 1.
- R10: An instruction whose handled mark is 1 is never captured, whatever its other marks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered |
| in_seq | input | SEQ_W | Instruction sequence number |
| in_ser_before | input | 1 | Serialize-before mark |
| in_ser_after | input | 1 | Serialize-after mark |
| in_ctrl_reg | input | 1 | Control-register access mark |
| in_store_cond | input | 1 | Store-conditional mark |
| in_handled | input | 1 | Serialization already handled |
| in_temp | input | 1 | Temporary serialization mark |
| in_ready | output | 1 | Instruction accepted this cycle if valid |
| be_empty | input | 1 | Back end holds no instructions |
| queue_count | input | QCNT_W | Fetch-queue occupancy |
| squash_valid | input | 1 | Squash request |
| squash_seq | input | SEQ_W | Youngest surviving sequence number |
| out_valid | output | 1 | Instruction emitted |
| out_seq | output | SEQ_W | Emitted sequence number |
| out_ser_before | output | 1 | Emitted serialize-before mark |
| out_handled | output | 1 | Emitted handled mark |
| blocked | output | 1 | Unit is in BLOCKED |
| complete | output | 1 | Unit is in COMPLETE |
| cnt_serializing | output | CNT_W | Serializing barriers plus serialize-after count |
| cnt_temporary | output | CNT_W | Temporary barrier count |
| cnt_stall | output | CNT_W | Cycles spent blocked |

## Verification
Timing of results:

- A forwarded instruction, the `blocked` flag after a capture, and the counter increments are all due one edge after the accepting edge.
- A held barrier appears two edges after the drain condition is first presented: one edge to enter COMPLETE and one to emit.
- A discarding squash clears `blocked` on the edge that sees it.

The bench drives every input just after a falling edge and samples one falling edge later. Each check therefore sits exactly one edge after its stimulus. The bench keeps its own expected counts for all three counters, incrementing them by the rule for each stimulus. It also sweeps all 64 combinations of the six marks, computing the expected class arithmetically.

// File: rtl/sbu_pkg.sv
package sbu_pkg;
    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_BLOCKED  = 2'd1,
        ST_COMPLETE = 2'd2
    } sbu_state_e;

    localparam int NUM_COUNTERS = 3;
    localparam int CIDX_SER   = 0;
    localparam int CIDX_TEMP  = 1;
    localparam int CIDX_STALL = 2;
endpackage

// File: rtl/sbu_classify.sv
module sbu_classify (
    input  logic pend_next,
    input  logic ser_before,
    input  logic ser_after,
    input  logic ctrl_reg,
    input  logic store_cond,
    input  logic handled,
    output logic eff_before,
    output logic is_barrier,
    output logic is_after
);
    always_comb begin
        // a pending serialize-after from the previous instruction turns this one into serialize-before
        eff_before = ser_before | pend_next;
        is_barrier = (eff_before | ctrl_reg) & ~handled;
        is_after   = ~is_barrier & (store_cond | ser_after) & ~handled;
    end
endmodule

// File: rtl/sbu_counter.sv
module sbu_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (inc) count <= count + 1'b1;
    end
endmodule

// File: rtl/sbu_fsm.sv
module sbu_fsm
    import sbu_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int QCNT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic              in_temp,
    input  logic              in_handled,
    input  logic              eff_before,
    input  logic              is_barrier,
    input  logic              is_after,
    input  logic              be_empty,
    input  logic [QCNT_W-1:0] queue_count,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              in_ready,
    output logic              pend_next,
    output logic              out_valid,
    output logic [SEQ_W-1:0]  out_seq,
    output logic              out_ser_before,
    output logic              out_handled,
    output logic              blocked,
    output logic              complete,
    output logic              inc_ser,
    output logic              inc_temp,
    output logic              inc_stall
);
    sbu_state_e       state, state_nx;
    logic [SEQ_W-1:0] bar_seq;
    logic             bar_handled;
    logic             accept, kill, drain_ok;

    always_comb begin
        in_ready  = (state == ST_RUN) && !squash_valid;
        accept    = in_valid && in_ready;
        kill      = squash_valid && (state != ST_RUN) && (squash_seq < bar_seq);
        drain_ok  = be_empty && (queue_count == '0);
        blocked   = (state == ST_BLOCKED);
        complete  = (state == ST_COMPLETE);
        inc_ser   = accept && ((is_barrier && !in_temp) || is_after);
        inc_temp  = accept && is_barrier && in_temp;
        inc_stall = (state == ST_BLOCKED);
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:      if (accept && is_barrier) state_nx = ST_BLOCKED;      // capture
            ST_BLOCKED:  if (kill)                 state_nx = ST_RUN;          // discard
                         else if (drain_ok)        state_nx = ST_COMPLETE;     // drain
            ST_COMPLETE:                           state_nx = ST_RUN;          // release or discard
            default:                               state_nx = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    // held barrier, pending flag and the output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bar_seq        <= '0;
            bar_handled    <= 1'b0;
            pend_next      <= 1'b0;
            out_valid      <= 1'b0;
            out_seq        <= '0;
            out_ser_before <= 1'b0;
            out_handled    <= 1'b0;
        end else begin
            out_valid <= 1'b0;
            if (accept) begin
                pend_next <= is_after;
                if (is_barrier) begin
                    bar_seq     <= in_seq;
                    bar_handled <= !in_temp;
                end else begin
                    out_valid      <= 1'b1;
                    out_seq        <= in_seq;
                    out_ser_before <= eff_before;
                    out_handled    <= in_handled | is_after;
                end
            end
            if (state == ST_COMPLETE && !kill) begin
                out_valid      <= 1'b1;
                out_seq        <= bar_seq;
                out_ser_before <= 1'b0;
                out_handled    <= bar_handled;
            end
        end
    end

    assert_blocked_silent_R3: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BLOCKED |=> !out_valid);

    assert_pend_consumed_R5: assert property (@(posedge clk) disable iff (!rst_n)
        accept && pend_next && !is_after |=> !pend_next);

    assert_hold_until_drain_R6: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_BLOCKED && !drain_ok && !kill |=> state == ST_BLOCKED);

    assert_release_clean_R7: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_COMPLETE && !kill |=> out_valid && !out_ser_before && out_seq == $past(bar_seq));

    assert_squash_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        kill |=> state == ST_RUN && !out_valid);
endmodule

// File: rtl/ser_barrier_unit.sv
module ser_barrier_unit
    import sbu_pkg::*;
#(
    parameter int SEQ_W  = 8,
    parameter int QCNT_W = 4,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [SEQ_W-1:0]  in_seq,
    input  logic              in_ser_before,
    input  logic              in_ser_after,
    input  logic              in_ctrl_reg,
    input  logic              in_store_cond,
    input  logic              in_handled,
    input  logic              in_temp,
    output logic              in_ready,
    input  logic              be_empty,
    input  logic [QCNT_W-1:0] queue_count,
    input  logic              squash_valid,
    input  logic [SEQ_W-1:0]  squash_seq,
    output logic              out_valid,
    output logic [SEQ_W-1:0]  out_seq,
    output logic              out_ser_before,
    output logic              out_handled,
    output logic              blocked,
    output logic              complete,
    output logic [CNT_W-1:0]  cnt_serializing,
    output logic [CNT_W-1:0]  cnt_temporary,
    output logic [CNT_W-1:0]  cnt_stall
);
    logic pend_next, eff_before, is_barrier, is_after;
    logic inc_ser, inc_temp, inc_stall;
    logic [NUM_COUNTERS-1:0] inc_vec;
    logic [CNT_W-1:0]        cnt_arr [NUM_COUNTERS];

    sbu_classify u_cls (
        .pend_next  (pend_next),
        .ser_before (in_ser_before),
        .ser_after  (in_ser_after),
        .ctrl_reg   (in_ctrl_reg),
        .store_cond (in_store_cond),
        .handled    (in_handled),
        .eff_before (eff_before),
        .is_barrier (is_barrier),
        .is_after   (is_after)
    );

    sbu_fsm #(.SEQ_W(SEQ_W), .QCNT_W(QCNT_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .in_seq         (in_seq),
        .in_temp        (in_temp),
        .in_handled     (in_handled),
        .eff_before     (eff_before),
        .is_barrier     (is_barrier),
        .is_after       (is_after),
        .be_empty       (be_empty),
        .queue_count    (queue_count),
        .squash_valid   (squash_valid),
        .squash_seq     (squash_seq),
        .in_ready       (in_ready),
        .pend_next      (pend_next),
        .out_valid      (out_valid),
        .out_seq        (out_seq),
        .out_ser_before (out_ser_before),
        .out_handled    (out_handled),
        .blocked        (blocked),
        .complete       (complete),
        .inc_ser        (inc_ser),
        .inc_temp       (inc_temp),
        .inc_stall      (inc_stall)
    );

    always_comb begin
        inc_vec             = '0;
        inc_vec[CIDX_SER]   = inc_ser;
        inc_vec[CIDX_TEMP]  = inc_temp;
        inc_vec[CIDX_STALL] = inc_stall;
    end

    for (genvar g = 0; g < NUM_COUNTERS; g++) begin : g_cnt
        sbu_counter #(.W(CNT_W)) u_c (
            .clk   (clk),
            .rst_n (rst_n),
            .inc   (inc_vec[g]),
            .count (cnt_arr[g])
        );
    end

    assign cnt_serializing = cnt_arr[CIDX_SER];
    assign cnt_temporary   = cnt_arr[CIDX_TEMP];
    assign cnt_stall       = cnt_arr[CIDX_STALL];

    assert_stall_step_R8: assert property (@(posedge clk) disable iff (!rst_n)
        blocked |=> cnt_stall == $past(cnt_stall) + 1'b1);

    assert_handled_not_captured_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && in_handled |=> !blocked);
endmodule

// File: tb/sim_ser_barrier_unit.sv
module sim_ser_barrier_unit;
    localparam int SEQ_W = 8, QCNT_W = 4, CNT_W = 16;

    logic clk = 1'b0;
    logic rst_n;
    logic in_valid, in_ser_before, in_ser_after, in_ctrl_reg, in_store_cond, in_handled, in_temp;
    logic [SEQ_W-1:0] in_seq, squash_seq, out_seq;
    logic in_ready, be_empty, squash_valid, out_valid, out_ser_before, out_handled, blocked, complete;
    logic [QCNT_W-1:0] queue_count;
    logic [CNT_W-1:0] cnt_serializing, cnt_temporary, cnt_stall;

    int n_chk = 0, n_fail = 0;
    int e_ser = 0, e_temp = 0, e_stall = 0;

    always #5 clk = ~clk;

    ser_barrier_unit #(.SEQ_W(SEQ_W), .QCNT_W(QCNT_W), .CNT_W(CNT_W)) u0 (.*);

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic idle();
        in_valid = 0; in_seq = '0; in_ser_before = 0; in_ser_after = 0;
        in_ctrl_reg = 0; in_store_cond = 0; in_handled = 0; in_temp = 0;
    endtask

    task automatic send(input int seq, input logic b, input logic a, input logic c,
                        input logic s, input logic h, input logic t);
        in_valid = 1; in_seq = seq[SEQ_W-1:0]; in_ser_before = b; in_ser_after = a;
        in_ctrl_reg = c; in_store_cond = s; in_handled = h; in_temp = t;
    endtask

    task automatic counters(input string req);
        check({req, " cnt_serializing"}, 32'(cnt_serializing), e_ser);
        check({req, " cnt_temporary"}, 32'(cnt_temporary), e_temp);
        check({req, " cnt_stall"}, 32'(cnt_stall), e_stall);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        idle();
        rst_n = 0; be_empty = 0; queue_count = '0; squash_valid = 0; squash_seq = '0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        // R1 reset state
        check("R1 in_ready", in_ready, 1);
        check("R1 out_valid", out_valid, 0);
        check("R1 blocked", blocked, 0);
        check("R1 complete", complete, 0);
        counters("R1");

        // R2 plain pass-through
        send(5, 0, 0, 0, 0, 0, 0); cyc(); idle();
        check("R2 out_valid", out_valid, 1);
        check("R2 out_seq", out_seq, 5);
        check("R2 ser_before", out_ser_before, 0);
        check("R2 handled", out_handled, 0);

        // R10 handled serialize-before passes with mark kept
        send(6, 1, 0, 1, 0, 1, 0); cyc(); idle();
        check("R10 blocked", blocked, 0);
        check("R10 out_seq", out_seq, 6);
        check("R10 ser_before", out_ser_before, 1);
        check("R10 handled", out_handled, 1);

        // R3/R4 capture, R6 partial drain conditions, R8 stall count
        queue_count = 3;
        send(10, 1, 0, 0, 0, 0, 0); cyc(); idle();
        e_ser++;
        check("R3 blocked", blocked, 1);
        check("R3 out_valid", out_valid, 0);
        check("R3 in_ready", in_ready, 0);
        counters("R4");
        be_empty = 1; queue_count = 2;
        repeat (4) begin cyc(); e_stall++; check("R6 still blocked (queue busy)", blocked, 1); end
        be_empty = 0; queue_count = 0;
        repeat (2) begin cyc(); e_stall++; check("R6 still blocked (back end busy)", blocked, 1); end
        counters("R8");
        be_empty = 1;
        cyc(); e_stall++;
        check("R6 complete", complete, 1);
        check("R7 no output yet", out_valid, 0);
        send(11, 0, 0, 0, 0, 0, 0);
        check("R7 in_ready in COMPLETE", in_ready, 0);
        cyc();
        check("R7 release valid", out_valid, 1);
        check("R7 release seq", out_seq, 10);
        check("R7 release ser_before", out_ser_before, 0);
        check("R4 release handled", out_handled, 1);
        check("R7 back in RUN", in_ready, 1);
        cyc(); idle();
        check("R7 held input accepted after release", out_seq, 11);
        check("R7 held input valid", out_valid, 1);
        counters("R8");
        be_empty = 0;

        // R9 squash handling on a temporary control-register barrier
        send(20, 0, 0, 1, 0, 0, 1); cyc(); idle();
        e_temp++;
        check("R3 ctrl-reg blocked", blocked, 1);
        squash_valid = 1; squash_seq = 25;
        cyc(); e_stall++;
        check("R9 younger squash ignored", blocked, 1);
        squash_seq = 20;
        cyc(); e_stall++;
        check("R9 equal squash ignored", blocked, 1);
        squash_seq = 15;
        check("R9 no accept during squash", in_ready, 0);
        cyc(); e_stall++;
        squash_valid = 0;
        check("R9 discard leaves blocked", blocked, 0);
        check("R9 discard no output", out_valid, 0);
        be_empty = 1;
        cyc();
        check("R9 barrier never emitted", out_valid, 0);
        counters("R9");

        // R4 temporary release keeps handled 0
        send(30, 1, 0, 0, 0, 0, 1); cyc(); idle();
        e_temp++;
        cyc(); e_stall++;
        check("R4 temp complete", complete, 1);
        cyc();
        check("R4 temp release seq", out_seq, 30);
        check("R4 temp release handled", out_handled, 0);
        counters("R4");
        be_empty = 0;

        // R5 store-conditional then following instruction becomes a barrier
        send(40, 0, 0, 0, 1, 0, 0); cyc(); idle();
        e_ser++;
        check("R5 sc forwarded", out_seq, 40);
        check("R5 sc handled", out_handled, 1);
        send(41, 0, 0, 0, 0, 0, 0); cyc(); idle();
        e_ser++;
        check("R5 follower captured", blocked, 1);
        be_empty = 1;
        cyc(); e_stall++;
        cyc();
        check("R5 follower released", out_seq, 41);
        check("R5 follower ser_before cleared", out_ser_before, 0);
        send(42, 0, 0, 0, 0, 0, 0); cyc(); idle();
        check("R5 flag cleared", out_ser_before, 0);
        check("R5 flag cleared no block", blocked, 0);
        be_empty = 0;

        // R5 serialize-after followed by handled instruction
        send(50, 0, 1, 0, 0, 0, 0); cyc(); idle();
        e_ser++;
        send(51, 0, 0, 0, 0, 1, 0); cyc(); idle();
        check("R5 handled follower ser_before", out_ser_before, 1);
        check("R5 handled follower seq", out_seq, 51);
        send(52, 0, 0, 0, 0, 0, 0); cyc(); idle();
        check("R5 third ser_before", out_ser_before, 0);
        // handled serialize-after sets no flag
        send(60, 0, 1, 0, 0, 1, 0); cyc(); idle();
        check("R5 handled after passes", out_handled, 1);
        send(61, 0, 0, 0, 0, 0, 0); cyc(); idle();
        check("R5 no flag from handled after", out_ser_before, 0);
        check("R5 no flag no block", blocked, 0);
        counters("R5");

        // R9 squash while in COMPLETE
        be_empty = 1;
        send(70, 1, 0, 0, 0, 0, 0); cyc(); idle();
        e_ser++;
        cyc(); e_stall++;
        check("R9 complete reached", complete, 1);
        squash_valid = 1; squash_seq = 65;
        cyc();
        squash_valid = 0;
        check("R9 complete discarded", out_valid, 0);
        check("R9 complete back to RUN", complete, 0);
        be_empty = 0;

        // sweep over all mark combinations
        for (int c = 0; c < 64; c++) begin
            logic b, a, cr, sc, h, t, bar, aft;
            b = c[0]; a = c[1]; cr = c[2]; sc = c[3]; h = c[4]; t = c[5];
            bar = (b | cr) & ~h;
            aft = ~bar & (sc | a) & ~h;
            send(100 + c, b, a, cr, sc, h, t); cyc(); idle();
            if (bar) begin
                if (t) e_temp++; else e_ser++;
                check("R3 sweep blocked", blocked, 1);
                be_empty = 1;
                cyc(); e_stall++;
                cyc();
                check("R7 sweep release seq", out_seq, 100 + c);
                check("R4 sweep release handled", out_handled, !t);
                check("R7 sweep release ser_before", out_ser_before, 0);
                be_empty = 0;
            end else begin
                check("R10 sweep not blocked", blocked, 0);
                check("R2 sweep seq", out_seq, 100 + c);
                check("R2 sweep ser_before", out_ser_before, b);
                check("R5 sweep handled", out_handled, h | aft);
                if (aft) begin
                    e_ser++;
                    send(200, 0, 0, 0, 0, 1, 0); cyc(); idle();
                    check("R5 sweep follower ser_before", out_ser_before, 1);
                end
            end
        end
        counters("R8 sweep");
        finish_run();
    end
endmodule